// File: doc/BRIEF.md
# Root Clock Source Selector

This block picks the root clock of a small system from four candidates: an alternate clock, a crystal-derived clock, that crystal clock divided by sixteen, and a PLL output. Every source is modelled as a one-cycle enable strobe inside a single system clock domain. The block emits the root strobe and a main strobe, and it reports the active source as a two-bit code. An optional pre-divider halves the raw crystal strobe before any other use of it, including the divide-by-sixteen path.

Software drives the block through a small register bus. One control register holds the source requests, the low-power options and four interrupt masks. One flag register holds four write-1-to-clear pending flags and a read-only bit that says the alternate clock is running. One status register gives the active source code and the low-power state. A change of source takes effect only after the requested source has strobed twice. The PLL is accepted only while both the lock input and the regulator-ready input are high. A PLL request made before then stays pending and completes by itself.

During low-power wait-for-interrupt, the main strobe comes from either the alternate clock or the divided-by-sixteen clock, whichever software has chosen. The root selection carries on unchanged underneath.

Top module: `clksw_top`

## Requirements
- R1: After reset the active source code is 0 (divided-by-sixteen crystal clock). The control register (address 0), the flag register (address 1), `irq` and `lowPower` are all zero.
- R2: With code 0 active and the pre-divider off, `rootStb` pulses exactly once for every 16 strobes of `xtalStb`. A root pulse in code 0 only ever coincides with an `xtalStb` pulse.
- R3: Control bit 0 (pre-divider) set makes only every second `xtalStb` count, so 128 crystal strobes give 4 root pulses in code 0.
- R4: Source codes are 0 = crystal/16, 1 = crystal, 2 = PLL, 3 = alternate. The target is chosen in this order: alternate if control bit 4 is set; otherwise crystal/16 if control bit 3 is clear; otherwise PLL if control bit 2, lock and regulator-ready are all high; otherwise crystal. A switch to a new target completes on the edge at which that target's second strobe is seen. A switch that enters or leaves code 0 sets flag bit 1 on that same edge. While code 1 is active, `rootStb` equals `xtalStb`.
- R5: Code 2 is entered only when lock and regulator-ready were both high in the previous cycle. A PLL request made while either is low leaves the crystal active. Once both are high, the request completes after two `pllStb` strobes with no further write.
- R6: A completed switch into or out of code 3 sets flag bit 2. Flag bit 4 reads 1 exactly while code 3 is active.
- R7: Writing 1 to bits 3:0 of the flag register clears the matching pending flags. Writing 0 leaves them unchanged.
- R8: `irq` is high exactly when some pending flag (bits 3:0) has its mask bit set. The masks are control bits 8 to 11, in flag order.
- R9: A rising edge of `pllLocked` sets flag bit 3. A rising edge of `stopReq` sets flag bit 0.
- R10: A `wfiExec` pulse sets `lowPower` only if control bit 5 is set. `wfiWake` clears it. While `lowPower` is high, `mainStb` follows `altStb` if control bit 1 is set, and the crystal/16 strobe otherwise. When `lowPower` is low, `mainStb` follows `rootStb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register address: 0 control, 1 flags, 2 status |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data for `regAddr` (combinational) |
| xtalStb | input | 1 | Raw crystal clock enable strobe |
| pllStb | input | 1 | PLL output enable strobe |
| altStb | input | 1 | Alternate clock enable strobe |
| pllLocked | input | 1 | PLL lock status |
| regReady | input | 1 | Main regulator ready status |
| stopReq | input | 1 | Stop request |
| wfiExec | input | 1 | Wait-for-interrupt executed pulse |
| wfiWake | input | 1 | Wake-up from wait-for-interrupt pulse |
| rootStb | output | 1 | Root clock enable strobe |
| mainStb | output | 1 | Main clock enable strobe |
| srcCode | output | 2 | Active source code |
| lowPower | output | 1 | Low-power wait state active |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a PLL request that is held back. The bench writes the PLL request while lock is low and strobes the PLL, then raises lock alone and strobes again. In both phases the crystal must stay active. Only after regulator-ready also rises do two PLL strobes complete the switch, with no further register write. A second difficult case is leaving the alternate clock for crystal/16. The bench supplies about forty crystal strobes, so that two divided pulses arrive. It then checks that the enter/leave flag and the alternate-switch flag are both set in the same flag register read.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int NUM_SRC = 4;
  localparam int NUM_FLAGS = 4;

  typedef enum logic [1:0] {
    SRC_DIV16 = 2'd0,
    SRC_XTAL  = 2'd1,
    SRC_PLL   = 2'd2,
    SRC_ALT   = 2'd3
  } srcSel_e;

  // control register field positions
  localparam int B_PREDIV = 0;
  localparam int B_WFIALT = 1;
  localparam int B_PLLSEL = 2;
  localparam int B_FULL   = 3;
  localparam int B_ALTSEL = 4;
  localparam int B_LPWFI  = 5;
  localparam int B_MASK0  = 8;

  // flag register positions
  localparam int F_STOP   = 0;
  localparam int F_FULL   = 1;
  localparam int F_ALT    = 2;
  localparam int F_LOCK   = 3;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_FLAGS  = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  // control strobes from control to datapath
  typedef struct packed {
    logic    preDiv;
    srcSel_e active;
    logic    lowPower;
    logic    lpUseAlt;
  } dpCtrl_t;

  // conditioned source strobes from datapath to control
  typedef struct packed {
    logic alt;
    logic pll;
    logic xtal;
    logic div16;
  } srcStb_t;
endpackage

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int DIV_RATIO = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCtrl_t ctrl,
  input  logic    xtalRaw,
  input  logic    pllRaw,
  input  logic    altRaw,
  output srcStb_t stb,
  output logic    rootStb,
  output logic    mainStb
);
  localparam int CNT_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);

  logic halfPhase;
  logic xtalEff;
  logic [CNT_W-1:0] divCnt;
  logic [NUM_SRC-1:0] stbVec;

  // pre-divider: only every second raw strobe passes when enabled
  always_ff @(posedge clk) begin
    if (!rstN) halfPhase <= 1'b0;
    else if (xtalRaw) halfPhase <= ~halfPhase;
  end

  assign xtalEff = xtalRaw && (!ctrl.preDiv || halfPhase);

  generate
    if ((1 << CNT_W) == DIV_RATIO) begin : g_pow2
      always_ff @(posedge clk) begin
        if (!rstN) divCnt <= '0;
        else if (xtalEff) divCnt <= divCnt + 1'b1;
      end
    end else begin : g_any
      always_ff @(posedge clk) begin
        if (!rstN) divCnt <= '0;
        else if (xtalEff) divCnt <= (divCnt == CNT_LAST) ? '0 : divCnt + 1'b1;
      end
    end
  endgenerate

  assign stb.div16 = xtalEff && (divCnt == CNT_LAST);
  assign stb.xtal  = xtalEff;
  assign stb.pll   = pllRaw;
  assign stb.alt   = altRaw;

  assign stbVec  = {stb.alt, stb.pll, stb.xtal, stb.div16};
  assign rootStb = stbVec[ctrl.active];
  assign mainStb = ctrl.lowPower ? (ctrl.lpUseAlt ? altRaw : stb.div16) : rootStb;
endmodule

// File: rtl/clksw_control.sv
module clksw_control
  import clksw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SETTLE_STROBES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           regAddr,
  input  logic                 regWe,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  input  srcStb_t              stb,
  input  logic                 pllLocked,
  input  logic                 regReady,
  input  logic                 stopReq,
  input  logic                 wfiExec,
  input  logic                 wfiWake,
  output dpCtrl_t              dpCtrl,
  output logic [1:0]           srcCode,
  output logic                 lowPower,
  output logic                 irq,
  output logic [NUM_FLAGS-1:0] pendFlags,
  output logic [NUM_FLAGS-1:0] irqMasks
);
  localparam int SET_W = $clog2(SETTLE_STROBES + 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_STROBES - 1);
  localparam logic [DATA_W-1:0] CTRL_WMASK = DATA_W'(16'h0F3F);

  logic [DATA_W-1:0] ctrlReg;
  srcSel_e active, target, tgtReg;
  logic [SET_W-1:0] settleCnt, cntEff;
  logic [NUM_SRC-1:0] stbVec;
  logic tgtStb, switchNow;
  logic stopQ, lockQ;
  logic [NUM_FLAGS-1:0] setVec, clrVec;

  // control register
  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (regWe && regAddr == ADDR_CTRL) ctrlReg <= regWdata & CTRL_WMASK;
  end

  // target selection, alternate has highest priority
  always_comb begin
    if (ctrlReg[B_ALTSEL]) target = SRC_ALT;
    else if (!ctrlReg[B_FULL]) target = SRC_DIV16;
    else if (ctrlReg[B_PLLSEL] && pllLocked && regReady) target = SRC_PLL;
    else target = SRC_XTAL;
  end

  assign stbVec    = {stb.alt, stb.pll, stb.xtal, stb.div16};
  assign tgtStb    = stbVec[target];
  assign cntEff    = (target == tgtReg) ? settleCnt : '0;
  assign switchNow = (target != active) && tgtStb && (cntEff == SET_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= SRC_DIV16;
      tgtReg    <= SRC_DIV16;
      settleCnt <= '0;
    end else begin
      tgtReg <= target;
      if (switchNow) active <= target;
      if (target == active || switchNow) settleCnt <= '0;
      else if (tgtStb) settleCnt <= cntEff + 1'b1;
      else settleCnt <= cntEff;
    end
  end

  // edge detectors for stop and lock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopQ <= 1'b0;
      lockQ <= 1'b0;
    end else begin
      stopQ <= stopReq;
      lockQ <= pllLocked;
    end
  end

  always_comb begin
    setVec         = '0;
    setVec[F_STOP] = stopReq && !stopQ;
    setVec[F_LOCK] = pllLocked && !lockQ;
    setVec[F_FULL] = switchNow && (target == SRC_DIV16 || active == SRC_DIV16);
    setVec[F_ALT]  = switchNow && (target == SRC_ALT || active == SRC_ALT);
  end

  assign clrVec = (regWe && regAddr == ADDR_FLAGS) ? regWdata[NUM_FLAGS-1:0] : '0;

  // one pending flag per source of interrupt, set wins over clear
  generate
    for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rstN) pendFlags[gi] <= 1'b0;
        else pendFlags[gi] <= setVec[gi] | (pendFlags[gi] & ~clrVec[gi]);
      end
    end
  endgenerate

  // low-power wait state
  always_ff @(posedge clk) begin
    if (!rstN) lowPower <= 1'b0;
    else if (wfiWake) lowPower <= 1'b0;
    else if (wfiExec && ctrlReg[B_LPWFI]) lowPower <= 1'b1;
  end

  assign irqMasks = ctrlReg[B_MASK0 +: NUM_FLAGS];
  assign irq      = |(pendFlags & irqMasks);
  assign srcCode  = active;

  always_comb begin
    case (regAddr)
      ADDR_CTRL:   regRdata = ctrlReg;
      ADDR_FLAGS:  regRdata = DATA_W'({active == SRC_ALT, pendFlags});
      ADDR_STATUS: regRdata = DATA_W'({lowPower, active});
      default:     regRdata = '0;
    endcase
  end

  assign dpCtrl.preDiv   = ctrlReg[B_PREDIV];
  assign dpCtrl.active   = active;
  assign dpCtrl.lowPower = lowPower;
  assign dpCtrl.lpUseAlt = ctrlReg[B_WFIALT];
endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_RATIO = 16,
  parameter int SETTLE_STROBES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              xtalStb,
  input  logic              pllStb,
  input  logic              altStb,
  input  logic              pllLocked,
  input  logic              regReady,
  input  logic              stopReq,
  input  logic              wfiExec,
  input  logic              wfiWake,
  output logic              rootStb,
  output logic              mainStb,
  output logic [1:0]        srcCode,
  output logic              lowPower,
  output logic              irq
);
  dpCtrl_t dpCtrl;
  srcStb_t srcStb;
  logic [NUM_FLAGS-1:0] pendFlags, irqMasks;

  clksw_control #(.DATA_W(DATA_W), .SETTLE_STROBES(SETTLE_STROBES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .stb(srcStb),
    .pllLocked(pllLocked), .regReady(regReady), .stopReq(stopReq),
    .wfiExec(wfiExec), .wfiWake(wfiWake), .dpCtrl(dpCtrl),
    .srcCode(srcCode), .lowPower(lowPower), .irq(irq),
    .pendFlags(pendFlags), .irqMasks(irqMasks)
  );

  clksw_datapath #(.DIV_RATIO(DIV_RATIO)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl), .xtalRaw(xtalStb),
    .pllRaw(pllStb), .altRaw(altStb), .stb(srcStb),
    .rootStb(rootStb), .mainStb(mainStb)
  );
endmodule

// File: rtl/clksw_checker.sv
module clksw_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] srcCode,
  input logic       pllLocked,
  input logic       regReady,
  input logic       rootStb,
  input logic       xtalStb,
  input logic       pllStb,
  input logic       lowPower,
  input logic       wfiExec,
  input logic [3:0] pendFlags,
  input logic [3:0] irqMasks,
  input logic       irq
);
  assert_pll_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (srcCode == 2'd2 && $past(srcCode) != 2'd2) |-> $past(pllLocked && regReady));

  assert_pll_root_R5: assert property (@(posedge clk) disable iff (!rstN)
    (srcCode == 2'd2 && rootStb) |-> pllStb);

  assert_div_from_xtal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (srcCode == 2'd0 && rootStb) |-> xtalStb);

  assert_div_switch_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (srcCode != $past(srcCode) && (srcCode == 2'd0 || $past(srcCode) == 2'd0)) |-> pendFlags[1]);

  assert_lock_pend_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pllLocked) |=> pendFlags[3]);

  assert_lp_entry_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowPower) |-> $past(wfiExec));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((pendFlags & irqMasks) != 4'd0));
endmodule

bind clksw_top clksw_checker u_chk (
  .clk(clk), .rstN(rstN), .srcCode(srcCode), .pllLocked(pllLocked),
  .regReady(regReady), .rootStb(rootStb), .xtalStb(xtalStb), .pllStb(pllStb),
  .lowPower(lowPower), .wfiExec(wfiExec), .pendFlags(pendFlags),
  .irqMasks(irqMasks), .irq(irq)
);

// File: tb/sim_clksw_top.sv
module sim_clksw_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_RDATA = 0, SEL_SRC = 1, SEL_ROOT = 2, SEL_MAIN = 3,
                 SEL_IRQ = 4, SEL_LP = 5, SEL_CNT = 6;

  typedef struct {
    string tag;
    int    sel;
    int    exp;
  } expItem_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic xtalStb = 0, pllStb = 0, altStb = 0, pllLocked = 0, regReady = 0;
  logic stopReq = 0, wfiExec = 0, wfiWake = 0;
  logic rootStb, mainStb, lowPower, irq;
  logic [1:0] srcCode;

  int testsRun = 0, testsFailed = 0;
  int pulseCnt = 0;
  bit finished = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clksw_top u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .xtalStb(xtalStb),
    .pllStb(pllStb), .altStb(altStb), .pllLocked(pllLocked),
    .regReady(regReady), .stopReq(stopReq), .wfiExec(wfiExec),
    .wfiWake(wfiWake), .rootStb(rootStb), .mainStb(mainStb),
    .srcCode(srcCode), .lowPower(lowPower), .irq(irq)
  );

  function automatic int probe(int sel);
    case (sel)
      SEL_RDATA: return int'(regRdata);
      SEL_SRC:   return int'(srcCode);
      SEL_ROOT:  return int'(rootStb);
      SEL_MAIN:  return int'(mainStb);
      SEL_IRQ:   return int'(irq);
      SEL_LP:    return int'(lowPower);
      default:   return pulseCnt;
    endcase
  endfunction

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      expItem_t it;
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      testsRun++;
      if (probe(it.sel) != it.exp) begin
        testsFailed++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, probe(it.sel), it.exp);
      end
    end
  end

  task automatic push(string tag, int sel, int exp);
    expItem_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
    #1;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic writeReg(logic [1:0] a, logic [15:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    tick();
    regWe = 1'b0;
  endtask

  task automatic readExp(logic [1:0] a, int exp, string tag);
    regAddr = a;
    push(tag, SEL_RDATA, exp);
  endtask

  // run n crystal strobes, counting root (useMain=0) or main pulses
  task automatic runXtal(int n, bit useMain);
    pulseCnt = 0;
    for (int i = 0; i < n; i++) begin
      xtalStb = 1'b1;
      #1;
      pulseCnt += useMain ? int'(mainStb) : int'(rootStb);
      tick();
    end
    xtalStb = 1'b0;
  endtask

  task automatic pulsePll(int n);
    for (int i = 0; i < n; i++) begin pllStb = 1'b1; tick(); end
    pllStb = 1'b0;
  endtask

  task automatic pulseAlt(int n);
    for (int i = 0; i < n; i++) begin altStb = 1'b1; tick(); end
    altStb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tick();
    // R1 reset state
    push("R1 source code", SEL_SRC, 0);
    readExp(2'd0, 0, "R1 control reg");
    readExp(2'd1, 0, "R1 flag reg");
    push("R1 irq", SEL_IRQ, 0);
    push("R1 lowPower", SEL_LP, 0);

    // R2 divide-by-16
    runXtal(128, 0);
    push("R2 root pulses /16", SEL_CNT, 8);

    // R3 pre-divider
    writeReg(2'd0, 16'h0001);
    runXtal(128, 0);
    push("R3 root pulses with pre-divider", SEL_CNT, 4);
    writeReg(2'd0, 16'h0000);

    // R4 switch to undivided crystal after two strobes
    writeReg(2'd0, 16'h0008);
    xtalStb = 1'b1; tick(); xtalStb = 1'b0;
    push("R4 no switch after one strobe", SEL_SRC, 0);
    xtalStb = 1'b1; tick(); xtalStb = 1'b0;
    push("R4 switch on second strobe", SEL_SRC, 1);
    readExp(2'd1, 16'h0002, "R4 div switch flag");
    push("R8 masked flag no irq", SEL_IRQ, 0);
    xtalStb = 1'b1; #1;
    push("R4 root follows crystal", SEL_ROOT, 1);
    xtalStb = 1'b0;
    writeReg(2'd0, 16'h0208);
    push("R8 irq when unmasked", SEL_IRQ, 1);
    writeReg(2'd1, 16'h0000);
    readExp(2'd1, 16'h0002, "R7 write zero keeps flag");
    writeReg(2'd1, 16'h0002);
    readExp(2'd1, 16'h0000, "R7 write one clears flag");
    push("R8 irq drops after clear", SEL_IRQ, 0);

    // R5 held PLL request
    writeReg(2'd0, 16'h020C);
    pulsePll(3);
    push("R5 no PLL without lock", SEL_SRC, 1);
    pllLocked = 1'b1;
    tick();
    pulsePll(2);
    push("R5 no PLL without regulator", SEL_SRC, 1);
    readExp(2'd1, 16'h0008, "R9 lock rise flag");
    regReady = 1'b1;
    pulsePll(1);
    push("R5 one PLL strobe not enough", SEL_SRC, 1);
    pulsePll(1);
    push("R5 pending PLL request completes", SEL_SRC, 2);
    writeReg(2'd1, 16'h000F);

    // R6 alternate clock
    writeReg(2'd0, 16'h041C);
    pulseAlt(2);
    push("R6 alternate active", SEL_SRC, 3);
    readExp(2'd1, 16'h0014, "R6 alt flag and status");
    push("R8 alt irq", SEL_IRQ, 1);
    writeReg(2'd1, 16'h0004);
    readExp(2'd1, 16'h0010, "R7 alt flag cleared");

    // R9 stop request
    stopReq = 1'b1; tick(); stopReq = 1'b0;
    readExp(2'd1, 16'h0011, "R9 stop flag");
    push("R8 stop masked", SEL_IRQ, 0);
    writeReg(2'd0, 16'h051C);
    push("R8 stop unmasked", SEL_IRQ, 1);
    writeReg(2'd1, 16'h0001);

    // R10 low-power wait
    wfiExec = 1'b1; tick(); wfiExec = 1'b0;
    push("R10 wfi ignored when disabled", SEL_LP, 0);
    writeReg(2'd0, 16'h053E);
    wfiExec = 1'b1; tick(); wfiExec = 1'b0;
    push("R10 low power entered", SEL_LP, 1);
    runXtal(128, 1);
    push("R10 main uses idle alternate", SEL_CNT, 0);
    altStb = 1'b1; #1;
    push("R10 main follows alternate", SEL_MAIN, 1);
    altStb = 1'b0;
    writeReg(2'd0, 16'h053C);
    runXtal(128, 1);
    push("R10 main uses divided crystal", SEL_CNT, 8);
    wfiWake = 1'b1; tick(); wfiWake = 1'b0;
    push("R10 wake clears low power", SEL_LP, 0);
    runXtal(32, 1);
    push("R10 main back on root", SEL_CNT, 0);

    // R4/R6 leave alternate for divided crystal
    writeReg(2'd0, 16'h0000);
    runXtal(40, 0);
    push("R4 back to divided crystal", SEL_SRC, 0);
    readExp(2'd1, 16'h0006, "R6 leaving alt sets both flags");

    tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule